// File: doc/BRIEF.md
# Inclusive Cache Core-Presence Snoop Filter

This block is the tag directory of a shared last-level cache that holds a superset of what four cores keep in their private caches. Each directory line carries a tag and one presence bit per core. A set bit means that core may still hold the line. A clear bit means it certainly does not. Requesters send line addresses with an operation code and a core number. One cycle later the block answers with hit or miss and with the set of cores that must be snooped.

Because the shared level includes every private copy, a miss shows that no core holds the data, and no snoop is issued. On a hit, only cores whose presence bit is set are named, and the requester never snoops itself. A miss allocates a way. When the chosen victim is still marked present in some cores, the block issues a back-invalidation to exactly those cores in the same cycle as the miss response. This keeps inclusion intact.

Top module: `sf_snoop_filter`

## Requirements
- R1: After reset the directory is empty: `rsp_valid_o` and `binv_valid_o` are low, and the first lookup of any address misses.
- R2: A request with op 0, 1 or 2 produces `rsp_valid_o` high in the cycle after it is sampled. Op 3 is reserved and produces no response, no back-invalidation and no state change.
- R3: On a miss of op 0 (shared read) or op 1 (exclusive read), `rsp_hit_o` is 0 and `rsp_snoop_o` is 0. The line is allocated with only the requester's presence bit set.
- R4: On a shared-read hit, `rsp_snoop_o` equals the line's presence vector with the requester's bit cleared. The requester's bit is then added to the line.
- R5: On an exclusive-read hit, `rsp_snoop_o` equals the presence vector without the requester. The vector then becomes the requester's bit only.
- R6: Op 2 (clean eviction notice) clears the requester's presence bit on a hit, keeps the line valid, and reports hit with zero snoop. On a miss it allocates nothing.
- R7: The miss victim is the lowest-index invalid way. If every way is valid, it is the lowest-index way with an all-zero presence vector. Otherwise it is the way chosen by a tree pseudo-LRU, in which a node bit of 0 points to the lower half.
- R8: When a miss replaces a valid line whose presence vector is nonzero, `binv_valid_o` rises with the response. `binv_addr_o` holds the victim's line address (tag above the set index), and `binv_mask_o` holds its presence vector. A victim with zero presence issues no back-invalidation.
- R9: The pseudo-LRU is updated toward the accessed way on read hits and fills. It is not updated on eviction notices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_op_i | input | 2 | 0 shared read, 1 exclusive read, 2 eviction notice, 3 reserved |
| req_core_i | input | 2 | Requesting core number |
| req_addr_i | input | 12 | Line address; the low 3 bits select the set |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Line present in directory |
| rsp_snoop_o | output | 4 | Cores to snoop, bit n for core n |
| binv_valid_o | output | 1 | Back-invalidation issued |
| binv_addr_o | output | 12 | Line address being invalidated |
| binv_mask_o | output | 4 | Cores receiving the back-invalidation |

## Verification
A miss response and the back-invalidation of its victim land in the same output cycle. The bench provokes this by filling all ways of a set with lines that each carry nonzero presence, touching one line to steer the pseudo-LRU, and then missing in that set. It judges the cycle as a whole: miss with zero snoop, together with the exact victim address and presence mask. A later lookup of the evicted address must miss. A companion case clears one line's presence first, so the same miss must prefer that way and leave the back-invalidation idle.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_EXCL  = 2'd1,
    OP_EVICT = 2'd2,
    OP_RSVD  = 2'd3
  } sf_op_e;
endpackage

// File: rtl/sf_way_match.sv
module sf_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 9,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way_o = WAY_W'(w);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/sf_victim_sel.sv
module sf_victim_sel #(
  parameter int WAYS  = 4,
  parameter int CORES = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int LVL   = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][CORES-1:0] pres_i,
  input  logic [WAYS-2:0]            plru_i,
  output logic [WAY_W-1:0]           victim_o
);
  logic [WAY_W-1:0] inv_way, idle_way, plru_way;
  logic             inv_found, idle_found;

  always_comb begin
    inv_way    = '0;
    idle_way   = '0;
    inv_found  = 1'b0;
    idle_found = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) begin
        inv_way   = WAY_W'(w);
        inv_found = 1'b1;
      end
      if (pres_i[w] == '0) begin
        idle_way   = WAY_W'(w);
        idle_found = 1'b1;
      end
    end
  end

  // tree walk: node bit 0 -> lower half
  always_comb begin
    int node;
    node = 0;
    for (int l = 0; l < LVL; l++) begin
      node = 2 * node + 1 + int'(plru_i[node]);
    end
    plru_way = WAY_W'(node - (WAYS - 1));
  end

  assign victim_o = inv_found  ? inv_way  :
                    idle_found ? idle_way : plru_way;
endmodule

// File: rtl/sf_snoop_filter.sv
module sf_snoop_filter
  import sf_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_SETS  = 8,
  parameter int NUM_WAYS  = 4,
  parameter int ADDR_W    = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  logic [1:0]                   req_op_i,
  input  logic [$clog2(NUM_CORES)-1:0] req_core_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  output logic                         rsp_valid_o,
  output logic                         rsp_hit_o,
  output logic [NUM_CORES-1:0]         rsp_snoop_o,
  output logic                         binv_valid_o,
  output logic [ADDR_W-1:0]            binv_addr_o,
  output logic [NUM_CORES-1:0]         binv_mask_o
);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int LVL   = $clog2(NUM_WAYS);

  logic [NUM_SETS-1:0][NUM_WAYS-1:0]                vld_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0]     tag_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][NUM_CORES-1:0] pres_q;
  logic [NUM_SETS-1:0][NUM_WAYS-2:0]                plru_q;

  sf_op_e               op;
  logic [SET_W-1:0]     set_idx;
  logic [TAG_W-1:0]     tag;
  logic [NUM_CORES-1:0] req_bit, hit_pres, new_pres, snoop_d;
  logic                 act, hit, lookup, wr_en, touch, binv_d;
  logic [WAY_W-1:0]     hit_way, victim, wr_way;
  logic [NUM_WAYS-2:0]  plru_n;

  assign op      = sf_op_e'(req_op_i);
  assign set_idx = req_addr_i[SET_W-1:0];
  assign tag     = req_addr_i[ADDR_W-1:SET_W];
  assign req_bit = NUM_CORES'(1) << req_core_i;
  assign act     = req_valid_i && (op != OP_RSVD);
  assign lookup  = act && (op != OP_EVICT);

  sf_way_match #(.WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match (
    .vld_i (vld_q[set_idx]),
    .tags_i(tag_q[set_idx]),
    .tag_i (tag),
    .hit_o (hit),
    .way_o (hit_way)
  );

  sf_victim_sel #(.WAYS(NUM_WAYS), .CORES(NUM_CORES)) u_victim (
    .vld_i   (vld_q[set_idx]),
    .pres_i  (pres_q[set_idx]),
    .plru_i  (plru_q[set_idx]),
    .victim_o(victim)
  );

  assign hit_pres = pres_q[set_idx][hit_way];
  assign wr_way   = hit ? hit_way : victim;
  assign wr_en    = act && (hit || op != OP_EVICT);
  assign touch    = lookup;

  always_comb begin
    unique case (op)
      OP_READ:  new_pres = hit ? (hit_pres | req_bit) : req_bit;
      OP_EXCL:  new_pres = req_bit;
      default:  new_pres = hit_pres & ~req_bit;
    endcase
  end

  // point every node on the path away from the accessed way
  always_comb begin
    int node, b;
    plru_n = plru_q[set_idx];
    node   = 0;
    for (int l = 0; l < LVL; l++) begin
      b            = int'(wr_way[LVL-1-l]);
      plru_n[node] = (b == 0);
      node         = 2 * node + 1 + b;
    end
  end

  assign snoop_d = (lookup && hit) ? (hit_pres & ~req_bit) : '0;
  assign binv_d  = lookup && !hit && vld_q[set_idx][victim] &&
                   (pres_q[set_idx][victim] != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q        <= '0;
      tag_q        <= '0;
      pres_q       <= '0;
      plru_q       <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_snoop_o  <= '0;
      binv_valid_o <= 1'b0;
      binv_addr_o  <= '0;
      binv_mask_o  <= '0;
    end else begin
      rsp_valid_o  <= act;
      rsp_hit_o    <= act && hit;
      rsp_snoop_o  <= snoop_d;
      binv_valid_o <= binv_d;
      binv_addr_o  <= {tag_q[set_idx][victim], set_idx};
      binv_mask_o  <= binv_d ? pres_q[set_idx][victim] : '0;
      if (wr_en) begin
        vld_q[set_idx][wr_way]  <= 1'b1;
        tag_q[set_idx][wr_way]  <= tag;
        pres_q[set_idx][wr_way] <= new_pres;
      end
      if (touch) plru_q[set_idx] <= plru_n;
    end
  end
endmodule

// File: rtl/sf_snoop_filter_chk.sv
module sf_snoop_filter_chk #(
  parameter int NUM_CORES = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_valid_i,
  input logic [1:0]                   req_op_i,
  input logic [$clog2(NUM_CORES)-1:0] req_core_i,
  input logic                         rsp_valid_o,
  input logic                         rsp_hit_o,
  input logic [NUM_CORES-1:0]         rsp_snoop_o,
  input logic                         binv_valid_o,
  input logic [NUM_CORES-1:0]         binv_mask_o
);
  AST_RSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i != 2'd3 |=> rsp_valid_o); // R2
  AST_RSVD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i == 2'd3 |=> !rsp_valid_o && !binv_valid_o); // R2
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2
  AST_MISS_NO_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> rsp_snoop_o == '0); // R3
  AST_NO_SELF_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_snoop_o & (NUM_CORES'(1) << $past(req_core_i))) == '0); // R4
  AST_BINV_WITH_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    binv_valid_o |-> rsp_valid_o && !rsp_hit_o); // R8
  AST_BINV_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    binv_valid_o |-> binv_mask_o != '0); // R8
endmodule

bind sf_snoop_filter sf_snoop_filter_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_core_i  (req_core_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_snoop_o (rsp_snoop_o),
  .binv_valid_o(binv_valid_o),
  .binv_mask_o (binv_mask_o)
);

// File: tb/tb_sf_snoop_filter.sv
module tb_sf_snoop_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = '0;
  logic [1:0]  req_core_i = '0;
  logic [11:0] req_addr_i = '0;
  logic        rsp_valid_o, rsp_hit_o, binv_valid_o;
  logic [3:0]  rsp_snoop_o, binv_mask_o;
  logic [11:0] binv_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        r_valid, r_hit, r_binv;
  logic [3:0]  r_snoop, r_mask;
  logic [11:0] r_baddr;

  sf_snoop_filter dut (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic logic [11:0] mk(int t, int s);
    return {9'(t), 3'(s)};
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic req(int op, int core, logic [11:0] addr);
    req_valid_i = 1'b1;
    req_op_i    = 2'(op);
    req_core_i  = 2'(core);
    req_addr_i  = addr;
    @(posedge clk_i);
    #1;
    req_valid_i = 1'b0;
    r_valid = rsp_valid_o;
    r_hit   = rsp_hit_o;
    r_snoop = rsp_snoop_o;
    r_binv  = binv_valid_o;
    r_mask  = binv_mask_o;
    r_baddr = binv_addr_o;
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid", 32'(rsp_valid_o), 0);
    chk("R1", "binv_valid", 32'(binv_valid_o), 0);
  endtask

  task automatic t_sharing();
    logic [11:0] a = mk(5, 1);
    req(0, 0, a);
    chk("R2", "rsp_valid", 32'(r_valid), 1);
    chk("R1", "first lookup hit", 32'(r_hit), 0);
    chk("R3", "miss snoop", 32'(r_snoop), 0);
    req(0, 1, a);
    chk("R4", "hit", 32'(r_hit), 1);
    chk("R4", "snoop c1", 32'(r_snoop), 32'h1);
    req(0, 2, a);
    chk("R4", "snoop c2", 32'(r_snoop), 32'h3);
    req(1, 3, a);
    chk("R5", "excl snoop", 32'(r_snoop), 32'h7);
    req(0, 0, a);
    chk("R5", "after excl snoop", 32'(r_snoop), 32'h8);
    req(2, 3, a);
    chk("R6", "notice hit", 32'(r_hit), 1);
    chk("R6", "notice snoop", 32'(r_snoop), 0);
    req(0, 1, a);
    chk("R6", "bit cleared snoop", 32'(r_snoop), 32'h1);
    req(3, 0, a);
    chk("R2", "reserved rsp_valid", 32'(r_valid), 0);
    chk("R2", "reserved binv", 32'(r_binv), 0);
    req(0, 2, a);
    chk("R2", "reserved no change snoop", 32'(r_snoop), 32'h3);
  endtask

  task automatic t_notice_miss();
    logic [11:0] a = mk(7, 4);
    req(2, 2, a);
    chk("R6", "notice miss hit", 32'(r_hit), 0);
    chk("R6", "notice miss binv", 32'(r_binv), 0);
    req(0, 1, a);
    chk("R6", "no allocation on notice", 32'(r_hit), 0);
    req(1, 3, mk(8, 4));
    chk("R3", "excl miss", 32'(r_hit), 0);
    req(0, 0, mk(8, 4));
    chk("R3", "alloc requester only", 32'(r_snoop), 32'h8);
  endtask

  task automatic t_plru_binv();
    for (int i = 0; i < 4; i++) begin
      req(0, i, mk(i + 1, 2));
      chk("R7", "fill into invalid way binv", 32'(r_binv), 0);
    end
    req(0, 1, mk(1, 2));
    chk("R9", "touch hit snoop", 32'(r_snoop), 32'h1);
    req(0, 0, mk(9, 2));
    chk("R8", "miss with binv hit", 32'(r_hit), 0);
    chk("R8", "miss with binv snoop", 32'(r_snoop), 0);
    chk("R8", "binv valid", 32'(r_binv), 1);
    chk("R9", "binv addr", 32'(r_baddr), 32'(mk(3, 2)));
    chk("R8", "binv mask", 32'(r_mask), 32'h4);
    req(0, 2, mk(3, 2));
    chk("R8", "evicted line misses", 32'(r_hit), 0);
    chk("R7", "plru next victim addr", 32'(r_baddr), 32'(mk(2, 2)));
    chk("R7", "plru next victim mask", 32'(r_mask), 32'h2);
  endtask

  task automatic t_idle_victim();
    for (int i = 0; i < 4; i++) req(0, i, mk(i + 1, 3));
    req(2, 1, mk(2, 3));
    chk("R6", "notice on line", 32'(r_hit), 1);
    req(0, 0, mk(9, 3));
    chk("R8", "zero presence victim binv", 32'(r_binv), 0);
    req(0, 2, mk(1, 3));
    chk("R7", "plru way kept", 32'(r_hit), 1);
    chk("R7", "kept line snoop", 32'(r_snoop), 32'h1);
    req(0, 1, mk(2, 3));
    chk("R7", "idle line replaced", 32'(r_hit), 0);
    chk("R9", "notice no plru touch addr", 32'(r_baddr), 32'(mk(3, 3)));
    chk("R8", "victim mask", 32'(r_mask), 32'h4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    t_reset();
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    t_sharing();
    t_notice_miss();
    t_plru_binv();
    t_idle_victim();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule